// File: doc/BRIEF.md
# Bus Isochronous Cycle Timer

This block keeps the 32-bit time value of a serial bus link controller. The value is split into three fields. A 7-bit seconds field sits at the top, a 13-bit cycle number in the middle and a 12-bit sub-cycle phase at the bottom. The phase advances on a 24.576 MHz tick enable, so 3072 ticks make one 125 µs bus cycle. 8000 cycles make one second.

When the node is the timing master, the value is the source for outgoing cycle-start timestamps. The cycle number can be paced either by the internal phase wrap or by an external 8 kHz strobe. That strobe is synchronised and edge-detected inside the block. Each rising edge clears the phase and advances the cycle number. If the strobe is late, the phase freezes at its last value instead of wrapping. When the node is not the master, each received cycle-start timestamp overwrites the whole value, and the timer free-runs from there.

A software write port loads all three fields at once. Reset affects only the strobe synchroniser and never the time value.

Top module: `cycle_timer`

## Requirements
- R1: `timer[31:25]` is the seconds field, `timer[24:12]` is the cycle number and `timer[11:0]` is the phase. A software write (`sw_we`=1) loads all three fields from `sw_data`, using the same bit positions, at the next clock edge.
- R2: With `ext_src`=0, the phase rises by one on each clock edge where both `tick_en` and `run_en` are 1 and the phase is below 3071. When either of them is 0, the phase is unchanged.
- R3: With `ext_src`=0, a counted tick at phase 3071 or above sets the phase to 0 and advances the cycle number by one.
- R4: With `ext_src`=1, a rising edge of `ext_strobe` sets the phase to 0 and advances the cycle number at the third rising clock edge after the strobe rises. This happens whatever the state of `tick_en` and `run_en`. A strobe held high acts once. With `ext_src`=0, the strobe has no effect.
- R5: With `ext_src`=1 and no strobe edge, counted ticks raise the phase only up to 3071. The phase then holds, and the cycle number does not change.
- R6: A cycle advance from cycle number 7999 or above sets the cycle number to 0 and increments the seconds field. The seconds field wraps from 127 to 0.
- R7: With `master`=0, `rx_load`=1 loads `rx_stamp` into the whole value at the next edge. With `master`=1, `rx_load` is ignored.
- R8: A software write takes priority over a received load and over counting in the same cycle.
- R9: Asserting `rst_n` low leaves the time value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the strobe synchroniser only |
| tick_en | input | 1 | 24.576 MHz time-base tick enable |
| run_en | input | 1 | Phase counting enable |
| ext_src | input | 1 | 1: cycle paced by external strobe; 0: by phase wrap |
| master | input | 1 | 1: node is the timing master |
| ext_strobe | input | 1 | Asynchronous 8 kHz cycle strobe |
| rx_load | input | 1 | Received cycle-start timestamp valid |
| rx_stamp | input | 32 | Received timestamp |
| sw_we | input | 1 | Software write strobe |
| sw_data | input | 32 | Software write value |
| timer | output | 32 | Current time value |

## Verification
Several rules are checked by assertions on every cycle: phase increment, internal wrap, external stall, strobe clear, the carry from cycle number into seconds, the one-cycle width of the strobe pulse, and the priority of load sources. The following behaviours can only be shown by the bench's scenarios: the three-edge latency from strobe to effect, the strobe acting once while held high, the strobe being ignored in internal mode, `rx_load` being ignored while master, and the value surviving reset. A randomized run, checked against a bench model, mixes modes, loads and strobes near the wrap points.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

  localparam int SEC_W   = 7;
  localparam int CNT_W   = 13;
  localparam int OFF_W   = 12;
  localparam int TIMER_W = SEC_W + CNT_W + OFF_W;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [CNT_W-1:0] cnt;
    logic [OFF_W-1:0] off;
  } ctmr_t;

  // phase has reached the last step of a cycle (or was loaded past it)
  function automatic logic off_at_end(logic [OFF_W-1:0] v, int lim);
    return int'(v) >= lim - 1;
  endfunction

  // cycle number has reached the last cycle of a second
  function automatic logic cnt_at_end(logic [CNT_W-1:0] v, int lim);
    return int'(v) >= lim - 1;
  endfunction

endpackage

// File: rtl/ctmr_strobe_sync.sv
module ctmr_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_in,
  output logic pulse
);

  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], strobe_in};
      last  <= chain[STAGES-1];
    end
  end

  assign pulse = chain[STAGES-1] & ~last;

  // one pulse per rising edge: never two cycles in a row
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

endmodule

// File: rtl/ctmr_offset.sv
module ctmr_offset
  import ctmr_pkg::*;
#(
  parameter int OFF_LIMIT = 3072
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFF_W-1:0] load_off,
  input  logic             tick,
  input  logic             run,
  input  logic             ext,
  input  logic             pulse,
  output logic [OFF_W-1:0] off,
  output logic             cycle_adv
);

  logic             counted;
  logic             at_end;
  logic [OFF_W-1:0] off_nxt;

  assign counted = tick & run;
  assign at_end  = off_at_end(off, OFF_LIMIT);

  always_comb begin
    off_nxt   = off;
    cycle_adv = 1'b0;
    if (ext) begin
      if (pulse) begin
        off_nxt   = '0;
        cycle_adv = 1'b1;
      end else if (counted && !at_end) begin
        off_nxt = off + 1'b1;
      end
    end else if (counted) begin
      if (at_end) begin
        off_nxt   = '0;
        cycle_adv = 1'b1;
      end else begin
        off_nxt = off + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load) off <= load_off;
    else      off <= off_nxt;
  end

  assert_off_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !ext && counted && !at_end) |=> off == $past(off) + 1'b1);

  assert_off_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !ext && !counted) |=> $stable(off));

  assert_off_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !ext && counted && at_end) |=> off == '0);

  assert_strobe_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && ext && pulse) |=> off == '0);

  assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && ext && !pulse && at_end) |=> $stable(off));

endmodule

// File: rtl/ctmr_cycle_sec.sv
module ctmr_cycle_sec
  import ctmr_pkg::*;
#(
  parameter int CNT_LIMIT = 8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic [SEC_W-1:0] load_sec,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt,
  output logic [SEC_W-1:0] sec
);

  logic sec_carry;

  assign sec_carry = adv & cnt_at_end(cnt, CNT_LIMIT);

  always_ff @(posedge clk) begin
    if (load) begin
      cnt <= load_cnt;
      sec <= load_sec;
    end else if (sec_carry) begin
      cnt <= '0;
      sec <= sec + 1'b1;
    end else if (adv) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_sec_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && sec_carry) |=> (cnt == '0) && (sec == $past(sec) + 1'b1));

  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv && !sec_carry) |=> (cnt == $past(cnt) + 1'b1) && $stable(sec));

  assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(cnt) && $stable(sec));

endmodule

// File: rtl/cycle_timer.sv
module cycle_timer
  import ctmr_pkg::*;
#(
  parameter int OFF_LIMIT   = 3072,
  parameter int CNT_LIMIT   = 8000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        run_en,
  input  logic        ext_src,
  input  logic        master,
  input  logic        ext_strobe,
  input  logic        rx_load,
  input  logic [31:0] rx_stamp,
  input  logic        sw_we,
  input  logic [31:0] sw_data,
  output logic [31:0] timer
);

  logic         strobe_pulse;
  logic         rx_take;
  logic         any_load;
  ctmr_t        load_val;
  ctmr_t        cur;
  logic         cycle_adv;

  ctmr_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe_in (ext_strobe),
    .pulse     (strobe_pulse)
  );

  // load source priority: software write, then received stamp (non-master)
  assign rx_take  = rx_load & ~master;
  assign any_load = sw_we | rx_take;
  assign load_val = sw_we ? ctmr_t'(sw_data) : ctmr_t'(rx_stamp);

  ctmr_offset #(.OFF_LIMIT(OFF_LIMIT)) u_off (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (any_load),
    .load_off  (load_val.off),
    .tick      (tick_en),
    .run       (run_en),
    .ext       (ext_src),
    .pulse     (strobe_pulse),
    .off       (cur.off),
    .cycle_adv (cycle_adv)
  );

  ctmr_cycle_sec #(.CNT_LIMIT(CNT_LIMIT)) u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (any_load),
    .load_cnt (load_val.cnt),
    .load_sec (load_val.sec),
    .adv      (cycle_adv),
    .cnt      (cur.cnt),
    .sec      (cur.sec)
  );

  assign timer = cur;

  assert_sw_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> timer == $past(sw_data));

  assert_rx_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && !master && !sw_we) |=> timer == $past(rx_stamp));

  assert_ext_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_src && !any_load && !tick_en) |=> $stable(timer));

endmodule

// File: tb/cycle_timer_test.sv
module cycle_timer_test;

  logic        clk = 1'b0;
  logic        rst_n, tick_en, run_en, ext_src, master, ext_strobe;
  logic        rx_load, sw_we;
  logic [31:0] rx_stamp, sw_data;
  logic [31:0] timer;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string cur_tag = "R2";

  always #4 clk = ~clk;  // 125 MHz

  cycle_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_en(run_en),
    .ext_src(ext_src), .master(master), .ext_strobe(ext_strobe),
    .rx_load(rx_load), .rx_stamp(rx_stamp), .sw_we(sw_we),
    .sw_data(sw_data), .timer(timer)
  );

  function automatic logic [31:0] pack(int s, int c, int o);
    logic [31:0] v;
    v = (32'(s) << 25) | (32'(c) << 12) | 32'(o);
    return v;
  endfunction

  // time value advanced by one clock, from the requirements
  function automatic logic [31:0] ref_step(logic [31:0] v, bit tk, bit rn, bit ex, bit pl);
    int s, c, o;
    bit carry;
    s = int'(v[31:25]); c = int'(v[24:12]); o = int'(v[11:0]);
    carry = 0;
    if (ex) begin
      if (pl) begin o = 0; carry = 1; end
      else if (tk && rn && o < 3071) o = o + 1;
    end else if (tk && rn) begin
      o = o + 1;
      if (o >= 3072) begin o = 0; carry = 1; end
    end
    if (carry) begin
      c = c + 1;
      if (c >= 8000) begin c = 0; s = (s + 1) % 128; end
    end
    return pack(s, c, o);
  endfunction

  // bench model
  logic [31:0] mdl;
  bit mdl_ok = 0;
  bit m1 = 0, m2 = 0, m3 = 0;

  always @(posedge clk) begin
    bit pl;
    pl = m2 & ~m3;
    if (sw_we) begin mdl = sw_data; mdl_ok = 1; end
    else if (rx_load && !master) begin mdl = rx_stamp; mdl_ok = 1; end
    else mdl = ref_step(mdl, tick_en, run_en, ext_src, pl);
    if (!rst_n) begin m1 = 0; m2 = 0; m3 = 0; end
    else begin m3 = m2; m2 = m1; m1 = ext_strobe; end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // continuous comparison against the model
  always @(negedge clk) if (mdl_ok) chk(cur_tag, timer, mdl);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [31:0] v);
    sw_we = 1; sw_data = v; cyc(1); sw_we = 0;
  endtask

  initial begin
    logic [31:0] keep;
    void'($urandom(32'h1394));
    rst_n = 0; tick_en = 0; run_en = 0; ext_src = 0; master = 0;
    ext_strobe = 0; rx_load = 0; sw_we = 0; rx_stamp = '0; sw_data = '0;
    cyc(3);
    rst_n = 1;

    // R8 / R1: write beats received load and counting
    cur_tag = "R8";
    tick_en = 1; run_en = 1; rx_load = 1; rx_stamp = pack(9, 9, 9);
    wr(pack(5, 100, 200));
    rx_load = 0;
    chk("R8", timer, pack(5, 100, 200));
    chk("R1", {25'd0, timer[31:25]}, 32'd5);
    chk("R1", {19'd0, timer[24:12]}, 32'd100);
    chk("R1", {20'd0, timer[11:0]}, 32'd200);

    // R2: counting and enable gating
    cur_tag = "R2";
    cyc(10);
    chk("R2", timer, pack(5, 100, 210));
    run_en = 0; cyc(5);
    chk("R2", timer, pack(5, 100, 210));
    run_en = 1; tick_en = 0; cyc(3);
    chk("R2", timer, pack(5, 100, 210));
    tick_en = 1;

    // R3: internal wrap
    cur_tag = "R3";
    wr(pack(2, 50, 3070));
    cyc(1); chk("R3", timer, pack(2, 50, 3071));
    cyc(1); chk("R3", timer, pack(2, 51, 0));
    wr(pack(2, 50, 4000));
    cyc(1); chk("R3", timer, pack(2, 51, 0));

    // R6: cycle and seconds wrap
    cur_tag = "R6";
    wr(pack(127, 7999, 3071));
    cyc(1); chk("R6", timer, pack(0, 0, 0));
    wr(pack(4, 7999, 3071));
    cyc(1); chk("R6", timer, pack(5, 0, 0));

    // R5: stall in external mode
    cur_tag = "R5";
    ext_src = 1;
    wr(pack(3, 10, 3069));
    cyc(2); chk("R5", timer, pack(3, 10, 3071));
    cyc(5); chk("R5", timer, pack(3, 10, 3071));

    // R4: strobe latency, single action while held
    cur_tag = "R4";
    ext_strobe = 1;
    cyc(2); chk("R4", timer, pack(3, 10, 3071));
    cyc(1); chk("R4", timer, pack(3, 11, 0));
    cyc(10); chk("R4", timer, pack(3, 11, 10));
    ext_strobe = 0; cyc(4);
    tick_en = 0;
    wr(pack(3, 20, 500));
    ext_strobe = 1; cyc(3);
    chk("R4", timer, pack(3, 21, 0));
    ext_strobe = 0; cyc(3);
    ext_src = 0;
    wr(pack(1, 1, 7));
    ext_strobe = 1; cyc(6);
    chk("R4", timer, pack(1, 1, 7));
    ext_strobe = 0; cyc(4);
    chk("R4", timer, pack(1, 1, 7));

    // R7: received stamp loads only when not master
    cur_tag = "R7";
    master = 1; rx_load = 1; rx_stamp = pack(60, 6000, 3000);
    cyc(1); rx_load = 0;
    chk("R7", timer, pack(1, 1, 7));
    master = 0; rx_load = 1;
    cyc(1); rx_load = 0;
    chk("R7", timer, pack(60, 6000, 3000));
    tick_en = 1; cyc(4);
    chk("R7", timer, pack(60, 6000, 3004));

    // R9: reset keeps the value
    cur_tag = "R9";
    tick_en = 0;
    keep = pack(77, 4321, 1234);
    wr(keep);
    rst_n = 0; cyc(4); rst_n = 1; cyc(1);
    chk("R9", timer, keep);

    // random mix checked against the model
    cur_tag = "R3";
    for (int i = 0; i < 6000; i++) begin
      tick_en = ($urandom_range(0, 9) < 7);
      run_en  = ($urandom_range(0, 19) != 0);
      if ($urandom_range(0, 299) == 0) ext_src = ~ext_src;
      if ($urandom_range(0, 199) == 0) master = ~master;
      if ($urandom_range(0, 149) == 0) ext_strobe = ~ext_strobe;
      rx_load  = ($urandom_range(0, 99) == 0);
      rx_stamp = pack($urandom_range(0, 127), $urandom_range(7990, 7999),
                      $urandom_range(3060, 3071));
      sw_we    = ($urandom_range(0, 249) == 0);
      sw_data  = pack($urandom_range(120, 127), $urandom_range(7995, 7999),
                      $urandom_range(3050, 3071));
      cyc(1);
    end
    sw_we = 0; rx_load = 0;
    cyc(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule